// File: doc/BRIEF.md
# Receive Idle Timeout and Transmit Break Unit

This unit sits beside a UART's serial paths. On the receive side it divides each bit period into sixteen ticks of the 16x baud enable and looks at the line once per bit, at the middle of the bit period. It counts how many complete character times the line has stayed HIGH at those samples. Once four whole characters of idle line have passed, it raises a timeout flag. The length of a character follows the programmed frame format, so the timeout window grows and shrinks with that format. The flag drops when a LOW sample shows that a new character has started, or when the host acknowledges it with a read strobe.

On the transmit side the unit sits between the serializer and the pin. When the registered break request is set, the pin is held LOW. The serializer keeps running behind the mask, and its output shows again once break is released.

Top module: `uib_idle_brk`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `idle_flag` and `mid_strobe` are 0, and break is released, so `tx_out` equals `ser_tx`.
- R2: A bit period is 16 accepted ticks (cycles with `tick16` high). Ticks in a period are numbered 0 to 15. The first tick after reset is number 0. A tick that sees `rx_line` LOW, when the line was HIGH at the previous tick, is number 0 of a new period. `mid_strobe` is a one-cycle pulse in the cycle after tick number 7, and the line is sampled at that tick.
- R3: A character time is 1 start bit, plus 5 + `width_code` data bits (`width_code` 0..3 gives 5..8 data bits), plus 1 bit if `parity_en` is set, plus 1 stop bit, or 2 stop bits if `two_stop` is set. The length is 7 to 12 bits.
- R4: `idle_flag` rises in the cycle after the mid-bit sample that completes the fourth consecutive character time in which every sample was HIGH. This is the same cycle as that sample's `mid_strobe`.
- R5: A LOW mid-bit sample clears the partial bit count and the character count, and clears `idle_flag` in the following cycle.
- R6: `rd_clr` high in a cycle clears `idle_flag` in the next cycle. A flag set on the same edge takes precedence. After a clear, the flag stays low until a LOW sample is followed by four more idle character times.
- R7: Cycles without `tick16` advance nothing. No strobe appears, the flag keeps its value unless `rd_clr` is high, and changes on `rx_line` between ticks are ignored.
- R8: One cycle after `brk_set` is sampled high, `tx_out` is 0 whatever `ser_tx` is. One cycle after `brk_set` is sampled low, `tx_out` follows `ser_tx` with no delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | 16x baud-rate enable, one cycle per tick |
| rx_line | input | 1 | Receive line, synchronous to `clk` |
| width_code | input | 2 | Data bits minus five |
| parity_en | input | 1 | Frame carries a parity bit |
| two_stop | input | 1 | Frame carries two stop bits |
| brk_set | input | 1 | Line-control break request |
| ser_tx | input | 1 | Serializer output |
| rd_clr | input | 1 | Host read strobe that clears the flag |
| idle_flag | output | 1 | Receive idle timeout flag |
| mid_strobe | output | 1 | Mid-bit sample pulse |
| tx_out | output | 1 | Transmit pin after the break mask |

## Verification
The bench counts the mid-bit samples between the end of a start bit and the rise of the flag for five frame formats. A unit that measured the window with a fixed length, or took the character length as one bit off, gives the wrong count. A LOW pulse after three idle characters has to restart the whole window, so a design that cleared only the bit counter would raise the flag too early. The bench also holds the read strobe high across the flag-set edge, pauses ticks while pulling the line LOW, and drives random serializer data under break. These expose a clear that beats the set, a sampler that looks at the line without a tick, and a break mask that leaks or adds a cycle.

// File: rtl/uib_pkg.sv
package uib_pkg;

    // Frame-length counter width: holds up to 12 bits per character.
    localparam int FRAME_LEN_W = 4;
    // Fixed part of a character: start + 5 data + 1 stop.
    localparam int FRAME_BASE  = 7;

    typedef struct packed {
        logic [1:0] width_code;
        logic       parity_en;
        logic       two_stop;
    } frame_fmt_t;

    function automatic logic [FRAME_LEN_W-1:0] frame_bits(frame_fmt_t f);
        return FRAME_LEN_W'(FRAME_BASE)
             + {{(FRAME_LEN_W-2){1'b0}}, f.width_code}
             + {{(FRAME_LEN_W-1){1'b0}}, f.parity_en}
             + {{(FRAME_LEN_W-1){1'b0}}, f.two_stop};
    endfunction

endpackage

// File: rtl/uib_bit_phase.sv
// Tracks the tick position inside the current bit period and marks the
// mid-bit sampling point. A HIGH-to-LOW step seen at a tick restarts the
// period so the sample lands in the middle of the start bit.
module uib_bit_phase #(
    parameter int TICKS_PER_BIT = 16,
    parameter int MID_TICK      = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rx,
    output logic sample_evt,
    output logic mid_pulse
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TICKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] MID_IDX  = CNT_W'(MID_TICK);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rx_prev;
        logic             pulse;
    } phase_st_t;

    phase_st_t st_d, st_q;
    logic      hit_d;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        hit_d      = 1'b0;
        if (tick) begin
            if (st_q.rx_prev && !rx) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == LAST_IDX) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.rx_prev = rx;
            hit_d        = (st_d.cnt == MID_IDX);
            st_d.pulse   = hit_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt     <= LAST_IDX;
            st_q.rx_prev <= 1'b1;
            st_q.pulse   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sample_evt = hit_d;
    assign mid_pulse  = st_q.pulse;

endmodule

// File: rtl/uib_idle_track.sv
// Counts idle bits and whole idle characters at each mid-bit sample and
// owns the timeout flag.
module uib_idle_track #(
    parameter int IDLE_CHARS = 4,
    parameter int LEN_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_evt,
    input  logic             rx,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             rd_clr,
    output logic             flag
);
    localparam int CH_W = $clog2(IDLE_CHARS + 1);
    localparam logic [CH_W-1:0] CH_LIMIT = CH_W'(IDLE_CHARS);

    typedef struct packed {
        logic [LEN_W-1:0] bits;
        logic [CH_W-1:0]  chars;
        logic             flag;
    } idle_st_t;

    idle_st_t       st_d, st_q;
    logic           set_ev, low_ev;
    logic [LEN_W:0] bits_inc;

    always_comb begin
        st_d     = st_q;
        set_ev   = 1'b0;
        low_ev   = 1'b0;
        bits_inc = {1'b0, st_q.bits} + 1'b1;
        if (sample_evt) begin
            if (!rx) begin
                low_ev     = 1'b1;
                st_d.bits  = '0;
                st_d.chars = '0;
            end else if (bits_inc >= {1'b0, frame_len}) begin
                st_d.bits = '0;
                if (st_q.chars != CH_LIMIT) begin
                    st_d.chars = st_q.chars + 1'b1;
                    set_ev     = (st_d.chars == CH_LIMIT);
                end
            end else begin
                st_d.bits = bits_inc[LEN_W-1:0];
            end
        end
        if (set_ev) begin
            st_d.flag = 1'b1;
        end else if (low_ev || rd_clr) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

endmodule

// File: rtl/uib_tx_break.sv
// Registers the break request and masks the serializer output with it.
module uib_tx_break (
    input  logic clk,
    input  logic rst,
    input  logic brk_req,
    input  logic ser_in,
    output logic tx
);
    typedef struct packed {
        logic brk;
    } brk_st_t;

    brk_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.brk = brk_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx = ser_in & ~st_q.brk;

endmodule

// File: rtl/uib_idle_brk.sv
module uib_idle_brk
    import uib_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16,
    parameter int MID_TICK      = 7,
    parameter int IDLE_CHARS    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick16,
    input  logic       rx_line,
    input  logic [1:0] width_code,
    input  logic       parity_en,
    input  logic       two_stop,
    input  logic       brk_set,
    input  logic       ser_tx,
    input  logic       rd_clr,
    output logic       idle_flag,
    output logic       mid_strobe,
    output logic       tx_out
);
    frame_fmt_t             fmt;
    logic [FRAME_LEN_W-1:0] frame_len;
    logic                   sample_evt;

    always_comb begin
        fmt.width_code = width_code;
        fmt.parity_en  = parity_en;
        fmt.two_stop   = two_stop;
        frame_len      = frame_bits(fmt);
    end

    uib_bit_phase #(
        .TICKS_PER_BIT(TICKS_PER_BIT),
        .MID_TICK     (MID_TICK)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .rx        (rx_line),
        .sample_evt(sample_evt),
        .mid_pulse (mid_strobe)
    );

    uib_idle_track #(
        .IDLE_CHARS(IDLE_CHARS),
        .LEN_W     (FRAME_LEN_W)
    ) u_idle (
        .clk       (clk),
        .rst       (rst),
        .sample_evt(sample_evt),
        .rx        (rx_line),
        .frame_len (frame_len),
        .rd_clr    (rd_clr),
        .flag      (idle_flag)
    );

    uib_tx_break u_brk (
        .clk    (clk),
        .rst    (rst),
        .brk_req(brk_set),
        .ser_in (ser_tx),
        .tx     (tx_out)
    );

endmodule

// File: rtl/uib_checker.sv
module uib_checker (
    input logic clk,
    input logic rst,
    input logic tick16,
    input logic rx_line,
    input logic brk_set,
    input logic ser_tx,
    input logic rd_clr,
    input logic idle_flag,
    input logic mid_strobe,
    input logic tx_out
);
    // R2: a strobe only follows a tick
    p_strobe_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        mid_strobe |-> $past(tick16));

    // R4: the flag only rises together with a HIGH mid-bit sample
    p_flag_rise_on_sample_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(idle_flag) |-> (mid_strobe && $past(rx_line)));

    // R5: a LOW sample leaves the flag clear
    p_low_sample_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (mid_strobe && !$past(rx_line)) |-> !idle_flag);

    // R7: no tick and no read strobe means nothing moves
    p_no_tick_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!$past(tick16) && !$past(rd_clr) && !$past(rst)) |-> ($stable(idle_flag) && !mid_strobe));

    // R8: break forces the pin low one cycle later
    p_break_low_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(brk_set) && !$past(rst)) |-> !tx_out);

    // R8: without break the pin follows the serializer
    p_break_release_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(brk_set)) |-> (tx_out == ser_tx));

endmodule

bind uib_idle_brk uib_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick16    (tick16),
    .rx_line   (rx_line),
    .brk_set   (brk_set),
    .ser_tx    (ser_tx),
    .rd_clr    (rd_clr),
    .idle_flag (idle_flag),
    .mid_strobe(mid_strobe),
    .tx_out    (tx_out)
);

// File: tb/uib_idle_brk_tb.sv
`timescale 1ns/1ps
module uib_idle_brk_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] width_code = 2'd0;
    logic       parity_en = 1'b0;
    logic       two_stop = 1'b0;
    logic       brk_set = 1'b0;
    logic       ser_tx = 1'b1;
    logic       rd_clr = 1'b0;
    logic       idle_flag, mid_strobe, tx_out;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    uib_idle_brk u_dut (
        .clk(clk), .rst(rst), .tick16(tick16), .rx_line(rx_line),
        .width_code(width_code), .parity_en(parity_en), .two_stop(two_stop),
        .brk_set(brk_set), .ser_tx(ser_tx), .rd_clr(rd_clr),
        .idle_flag(idle_flag), .mid_strobe(mid_strobe), .tx_out(tx_out)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- stimulus helpers ----------------
    bit tick_on = 1'b1;
    int tick_div = 0;
    always @(negedge clk) begin
        tick_div = (tick_div + 1) % 3;
        tick16 = tick_on && (tick_div == 0);
        ser_tx = 1'($urandom % 2);
    end

    function automatic int flen();
        return 7 + int'(width_code) + int'(parity_en) + int'(two_stop);
    endfunction

    task automatic wait_ticks(input int n);
        int k = 0;
        while (k < n) begin
            @(posedge clk);
            if (tick16) k++;
        end
        @(negedge clk);
    endtask

    // ---------------- behavioural reference ----------------
    int m_ph, m_bits, m_chars, m_len;
    bit m_prev, m_flag, m_brk, m_strobe, m_set, m_low;
    always @(posedge clk) begin
        if (rst) begin
            m_ph = 15; m_prev = 1; m_bits = 0; m_chars = 0;
            m_flag = 0; m_brk = 0; m_strobe = 0;
        end else begin
            m_set = 0; m_low = 0; m_strobe = 0;
            m_len = flen();
            if (tick16) begin
                if (m_prev && !rx_line) m_ph = 0;
                else m_ph = (m_ph + 1) % 16;
                m_prev = rx_line;
                if (m_ph == 7) begin
                    m_strobe = 1;
                    if (!rx_line) begin
                        m_bits = 0; m_chars = 0; m_low = 1;
                    end else begin
                        m_bits++;
                        if (m_bits >= m_len) begin
                            m_bits = 0;
                            if (m_chars < 4) begin
                                m_chars++;
                                if (m_chars == 4) m_set = 1;
                            end
                        end
                    end
                end
            end
            if (m_set) m_flag = 1;
            else if (m_low || rd_clr) m_flag = 0;
            m_brk = brk_set;
        end
    end

    // ---------------- per-cycle compare and monitors ----------------
    bit started = 0;
    bit cnt_en = 0;
    int s_cnt = 0;
    int got_cnt = -1;
    int rises = 0;
    int pause_strobes = 0;
    bit in_pause = 0;
    bit flag_prev = 0;
    always @(negedge clk) begin
        #1;
        if (started) begin
            check("R2", int'(mid_strobe), int'(m_strobe), "mid_strobe vs model");
            check("R4", int'(idle_flag), int'(m_flag), "idle_flag vs model");
            check("R8", int'(tx_out), int'(m_brk ? 1'b0 : ser_tx), "tx_out vs model");
            if (cnt_en && mid_strobe) s_cnt++;
            if (cnt_en && idle_flag) begin got_cnt = s_cnt; cnt_en = 0; end
            if (idle_flag && !flag_prev) rises++;
            if (in_pause && mid_strobe) pause_strobes++;
            flag_prev = idle_flag;
        end
    end

    // start bit then idle line; count samples until the flag rises
    task automatic start_then_idle();
        rx_line = 1'b0;
        wait_ticks(16);
        rx_line = 1'b1;
        s_cnt = 0; got_cnt = -1; cnt_en = 1;
    endtask

    task automatic run_format(input int w, input int p, input int s);
        int r0;
        width_code = 2'(w); parity_en = 1'(p); two_stop = 1'(s);
        r0 = rises;
        start_then_idle();
        wait_ticks(4 * flen() * 16 + 8);
        check("R3", got_cnt, 4 * flen(), "idle samples to timeout");
        check("R4", int'(idle_flag), 1, "flag after four idle characters");
        check("R4", rises - r0, 1, "single flag rise");
    endtask

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc >= 180000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired act=%0d exp=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", int'(idle_flag), 0, "flag in reset");
        check("R1", int'(mid_strobe), 0, "strobe in reset");
        check("R1", int'(tx_out), int'(ser_tx), "tx follows serializer in reset");
        @(posedge clk); started = 1;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R1", int'(idle_flag), 0, "flag after reset");

        // several frame formats (R3, R4)
        run_format(3, 0, 0);
        run_format(0, 0, 0);
        run_format(2, 1, 1);
        run_format(3, 1, 1);
        run_format(1, 0, 1);

        // host clear, then flag must stay low on continuing idle (R6)
        rd_clr = 1'b1; @(negedge clk); rd_clr = 1'b0;
        #1;
        check("R6", int'(idle_flag), 0, "flag cleared by read strobe");
        wait_ticks(5 * flen() * 16);
        #1;
        check("R6", int'(idle_flag), 0, "no re-arm without new character");

        // partial idle then LOW pulse restarts the window (R5)
        width_code = 2'd3; parity_en = 1'b0; two_stop = 1'b0;
        start_then_idle();
        cnt_en = 0;
        wait_ticks(3 * flen() * 16);
        rx_line = 1'b0;
        wait_ticks(10);
        rx_line = 1'b1;
        #1;
        check("R5", int'(idle_flag), 0, "no flag after three idle chars and LOW");
        s_cnt = 0; got_cnt = -1; cnt_en = 1;
        wait_ticks(4 * flen() * 16 + 24);
        check("R5", got_cnt >= 4 * flen() ? 1 : 0, 1, "window restarted after LOW sample");
        check("R5", int'(idle_flag), 1, "flag after full window");

        // a LOW sample clears a set flag (R5)
        rx_line = 1'b0;
        wait_ticks(16);
        #1;
        check("R5", int'(idle_flag), 0, "LOW sample clears flag");
        rx_line = 1'b1;
        wait_ticks(4 * flen() * 16 + 8);

        // ticks paused: LOW line without ticks is ignored (R7)
        check("R7", int'(idle_flag), 1, "flag set before pause");
        tick_on = 1'b0;
        repeat (4) @(negedge clk);
        in_pause = 1;
        rx_line = 1'b0;
        repeat (30) @(negedge clk);
        rx_line = 1'b1;
        repeat (30) @(negedge clk);
        in_pause = 0;
        #1;
        check("R7", pause_strobes, 0, "no strobe while ticks stopped");
        check("R7", int'(idle_flag), 1, "flag kept while ticks stopped");
        tick_on = 1'b1;
        wait_ticks(40);
        check("R7", int'(idle_flag), 1, "flag kept after ticks resume");

        // read strobe held across the set edge: set wins for one cycle (R6)
        begin
            int r0;
            r0 = rises;
            rd_clr = 1'b1;
            start_then_idle();
            wait_ticks(4 * flen() * 16 + 8);
            #1;
            check("R6", rises - r0, 1, "set beats simultaneous clear");
            check("R6", int'(idle_flag), 0, "clear applies next cycle");
            @(negedge clk);
            rd_clr = 1'b0;
        end

        // break masking (R8)
        brk_set = 1'b1;
        @(negedge clk); @(negedge clk);
        begin
            int highs = 0;
            for (int i = 0; i < 40; i++) begin
                #1;
                if (tx_out) highs++;
                @(negedge clk);
            end
            check("R8", highs, 0, "tx held low under break");
        end
        brk_set = 1'b0;
        @(negedge clk); @(negedge clk);
        #1;
        check("R8", int'(tx_out), int'(ser_tx), "tx follows serializer after release");

        repeat (5) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule